// File: doc/BRIEF.md
# Bidirectional GPIO Port Register

An 8-bit general-purpose I/O port that sits on a microcontroller's internal register bus. It holds an output latch and a per-pin output-mode register. From these it produces per-pin output-data and output-enable signals for external tristate pad cells. Each pin can drive push-pull, or act as open-drain, where a latched 1 releases the pin to high impedance.

The bus side offers two registers: the data latch and the mode register. Each can be written as a full byte, or one bit can be set, cleared or written while the other seven bits stay as they are. A normal read of the data register returns the pin levels after a two-flop synchronizer. A read tagged as read-modify-write returns the latch contents instead, so that a bit operation done by software never copies an external pin level back into the latch.

Each pin also has an alternate-function override. While it is selected, the alternate source supplies the pin's output value. The pin's open-drain or push-pull mode still applies, and the latch keeps its stored value.

Top module: `gpio_port`

## Requirements
- R1: After reset the data latch is 8'hFF and the mode register is 8'h00, so every pad output enable is 0.
- R2: A byte write (wr_op_i = 0) with reg_sel_i = 0 replaces the whole data latch at the next clock edge.
- R3: The bit operations change only bit bit_sel_i of the selected register: set (wr_op_i = 1), clear (wr_op_i = 2), and write of wdata_i[0] (wr_op_i = 3).
- R4: The mode register (reg_sel_i = 1) can be written and read. A read in the same cycle as a write returns the value held before the write.
- R5: When a pin's mode bit is 0 (open-drain), a source value of 0 gives pad_oe_o = 1 and pad_out_o = 0, and a source value of 1 gives pad_oe_o = 0 and pad_out_o = 0.
- R6: When a pin's mode bit is 1 (push-pull), pad_oe_o = 1 and pad_out_o equals the source value.
- R7: A normal read (rmw_i = 0, reg_sel_i = 0) returns the pin levels through a two-flop synchronizer. A change at the inputs is visible after the second clock edge and not after the first. A bit whose in_en_i is 0 reads as 0.
- R8: A read with rmw_i = 1 and reg_sel_i = 0 returns the data latch, whatever the pin levels are.
- R9: When alt_sel_i[n] = 1, pin n takes its source value from alt_out_i[n] under the same mode rules, and the data latch does not change.
- R10: Without req_i, or with req_i = 1 and we_i = 0, neither register changes. rdata_o is 0 when req_i is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| reg_sel_i | input | 1 | 0 = data latch, 1 = mode register |
| wr_op_i | input | 2 | 0 byte, 1 bit set, 2 bit clear, 3 bit write |
| bit_sel_i | input | 3 | Bit index for the bit operations |
| wdata_i | input | 8 | Write data |
| rmw_i | input | 1 | Read is part of a read-modify-write |
| rdata_o | output | 8 | Read data (combinational) |
| pin_i | input | 8 | Pin levels from the pads |
| in_en_i | input | 8 | Per-pin digital input enable |
| alt_sel_i | input | 8 | Per-pin alternate-function select |
| alt_out_i | input | 8 | Alternate-function output values |
| pad_out_o | output | 8 | Pad output data |
| pad_oe_o | output | 8 | Pad output enable |

## Verification
Random sequences of byte writes and the three bit operations are applied to both registers, with random indices and data. These separate a correct single-bit update from one that disturbs neighbouring bits or uses the wrong data bit. Pin levels are driven to differ from the latch, and each is read both normally and as read-modify-write, which shows whether the correct source is selected. Directed cases cover synchronizer latency, disabled inputs, a read in the same cycle as a write, alternate override in both modes, and idle or read-only accesses that must leave the registers unchanged.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    OP_BYTE = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_BIT  = 2'd3
  } wr_op_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_reg.sv
module gpio_reg
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH   = 8,
  parameter logic [WIDTH-1:0] RST_VAL = '0,
  localparam int              IDX_W   = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       op_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q, nxt, mask;
  wr_op_e op;

  assign op   = wr_op_e'(op_i);
  assign mask = WIDTH'(1) << idx_i;

  always_comb begin
    unique case (op)
      OP_BYTE: nxt = wdata_i;
      OP_SET:  nxt = q | mask;
      OP_CLR:  nxt = q & ~mask;
      default: nxt = wdata_i[0] ? (q | mask) : (q & ~mask);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= RST_VAL;
    else if (wr_en_i) q <= nxt;
  end

  assign q_o = q;
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] latch_i,
  input  logic [WIDTH-1:0] mode_i,
  input  logic [WIDTH-1:0] alt_sel_i,
  input  logic [WIDTH-1:0] alt_out_i,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_oe_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic src;
    assign src = alt_sel_i[i] ? alt_out_i[i] : latch_i[i];
    // push-pull always drives; open-drain drives only a low
    assign pad_oe_o[i]  = mode_i[i] | ~src;
    assign pad_out_o[i] = mode_i[i] & src;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int  WIDTH = 8,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic             reg_sel_i,
  input  logic [1:0]       wr_op_i,
  input  logic [IDX_W-1:0] bit_sel_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             rmw_i,
  output logic [WIDTH-1:0] rdata_o,
  input  logic [WIDTH-1:0] pin_i,
  input  logic [WIDTH-1:0] in_en_i,
  input  logic [WIDTH-1:0] alt_sel_i,
  input  logic [WIDTH-1:0] alt_out_i,
  output logic [WIDTH-1:0] pad_out_o,
  output logic [WIDTH-1:0] pad_oe_o
);
  logic [WIDTH-1:0] latch_q, mode_q, pin_sync;
  logic             wr_latch, wr_mode;

  assign wr_latch = req_i & we_i & ~reg_sel_i;
  assign wr_mode  = req_i & we_i &  reg_sel_i;

  gpio_reg #(.WIDTH(WIDTH), .RST_VAL({WIDTH{1'b1}})) u_latch (
    .clk_i, .rst_ni, .wr_en_i(wr_latch), .op_i(wr_op_i),
    .idx_i(bit_sel_i), .wdata_i, .q_o(latch_q)
  );

  gpio_reg #(.WIDTH(WIDTH), .RST_VAL('0)) u_mode (
    .clk_i, .rst_ni, .wr_en_i(wr_mode), .op_i(wr_op_i),
    .idx_i(bit_sel_i), .wdata_i, .q_o(mode_q)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_sync)
  );

  gpio_pad_drive #(.WIDTH(WIDTH)) u_drive (
    .latch_i(latch_q), .mode_i(mode_q), .alt_sel_i, .alt_out_i,
    .pad_out_o, .pad_oe_o
  );

  always_comb begin
    if (!req_i)        rdata_o = '0;
    else if (reg_sel_i) rdata_o = mode_q;
    else if (rmw_i)     rdata_o = latch_q;
    else                rdata_o = pin_sync & in_en_i;
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int  WIDTH = 8,
  localparam int IDX_W = $clog2(WIDTH)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic             reg_sel_i,
  input logic [1:0]       wr_op_i,
  input logic [IDX_W-1:0] bit_sel_i,
  input logic             rmw_i,
  input logic [WIDTH-1:0] rdata_o,
  input logic [WIDTH-1:0] in_en_i,
  input logic [WIDTH-1:0] pad_out_o,
  input logic [WIDTH-1:0] pad_oe_o,
  input logic [WIDTH-1:0] latch_q,
  input logic [WIDTH-1:0] mode_q
);
  a_r5_od_never_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_out_o & ~mode_q) == '0);

  a_r6_pp_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q & ~pad_oe_o) == '0);

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> ($stable(latch_q) && $stable(mode_q)));

  a_r3_bit_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !reg_sel_i && wr_op_i != 2'd0) |=>
      ((latch_q ^ $past(latch_q)) & ~(WIDTH'(1) << $past(bit_sel_i))) == '0);

  a_r8_rmw_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !reg_sel_i && rmw_i) |-> rdata_o == latch_q);

  a_r7_in_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !reg_sel_i && !rmw_i) |-> (rdata_o & ~in_en_i) == '0);
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
  .reg_sel_i(reg_sel_i), .wr_op_i(wr_op_i), .bit_sel_i(bit_sel_i),
  .rmw_i(rmw_i), .rdata_o(rdata_o), .in_en_i(in_en_i),
  .pad_out_o(pad_out_o), .pad_oe_o(pad_oe_o),
  .latch_q(latch_q), .mode_q(mode_q)
);

// File: tb/gpio_port_tb_top.sv
`timescale 1ns/1ps
module gpio_port_tb_top;
  logic       clk_i = 0, rst_ni = 0;
  logic       req_i = 0, we_i = 0, reg_sel_i = 0, rmw_i = 0;
  logic [1:0] wr_op_i = 0;
  logic [2:0] bit_sel_i = 0;
  logic [7:0] wdata_i = 0, pin_i = 0, in_en_i = 8'hFF, alt_sel_i = 0, alt_out_i = 0;
  logic [7:0] rdata_o, pad_out_o, pad_oe_o;

  int checks = 0, fails = 0;
  logic [7:0] exp_latch, exp_mode, rd;
  int unsigned seed = 32'd20240611;

  always #10 clk_i = ~clk_i;

  gpio_port dut_i (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_upd(input logic [7:0] old, input logic [1:0] op,
                                           input logic [2:0] idx, input logic [7:0] wd);
    logic [7:0] r = old;
    case (op)
      2'd0: r = wd;
      2'd1: r[idx] = 1'b1;
      2'd2: r[idx] = 1'b0;
      default: r[idx] = wd[0];
    endcase
    return r;
  endfunction

  function automatic logic [15:0] model_pad(input logic [7:0] latch, input logic [7:0] mode,
                                            input logic [7:0] asel, input logic [7:0] aout);
    logic [7:0] oe, out;
    for (int i = 0; i < 8; i++) begin
      logic s = asel[i] ? aout[i] : latch[i];
      if (mode[i]) begin oe[i] = 1'b1; out[i] = s; end
      else begin oe[i] = ~s; out[i] = 1'b0; end
    end
    return {oe, out};
  endfunction

  task automatic wr(input logic sel, input logic [1:0] op, input logic [2:0] idx, input logic [7:0] wd);
    @(negedge clk_i);
    req_i = 1; we_i = 1; reg_sel_i = sel; wr_op_i = op; bit_sel_i = idx; wdata_i = wd;
    @(posedge clk_i); #1;
    req_i = 0; we_i = 0;
    if (sel) exp_mode = model_upd(exp_mode, op, idx, wd);
    else     exp_latch = model_upd(exp_latch, op, idx, wd);
  endtask

  task automatic rdreg(input logic sel, input logic rmw, output logic [7:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 0; reg_sel_i = sel; rmw_i = rmw;
    #2 d = rdata_o;
    #1 req_i = 0; rmw_i = 0;
  endtask

  task automatic check_pads(input string req);
    logic [15:0] e;
    #1 e = model_pad(exp_latch, exp_mode, alt_sel_i, alt_out_i);
    check({req, " oe"}, pad_oe_o, e[15:8]);
    check({req, " out"}, pad_out_o, e[7:0]);
  endtask

  initial begin : wdog
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(seed));
    exp_latch = 8'hFF; exp_mode = 8'h00;
    #45 rst_ni = 1;
    // R1 reset state
    check("R1 oe", pad_oe_o, 8'h00);
    rdreg(0, 1, rd); check("R1 latch", rd, 8'hFF);
    rdreg(1, 0, rd); check("R1 mode", rd, 8'h00);
    check("R10 rdata idle", rdata_o, 8'h00);

    // R2 byte write, R5 open-drain
    wr(0, 2'd0, 0, 8'hA5);
    rdreg(0, 1, rd); check("R2 byte write", rd, 8'hA5);
    check_pads("R5 open-drain");

    // R3 bit ops on latch
    wr(0, 2'd1, 3'd1, 8'h00); rdreg(0, 1, rd); check("R3 set", rd, exp_latch);
    wr(0, 2'd2, 3'd7, 8'hFF); rdreg(0, 1, rd); check("R3 clear", rd, exp_latch);
    wr(0, 2'd3, 3'd4, 8'hFE); rdreg(0, 1, rd); check("R3 write0", rd, exp_latch);
    wr(0, 2'd3, 3'd6, 8'h01); rdreg(0, 1, rd); check("R3 write1", rd, exp_latch);

    // R4 same-cycle read returns old mode
    @(negedge clk_i);
    req_i = 1; we_i = 1; reg_sel_i = 1; wr_op_i = 0; wdata_i = 8'h3C;
    #2 check("R4 read during write", rdata_o, exp_mode);
    @(posedge clk_i); #1 req_i = 0; we_i = 0; exp_mode = 8'h3C;
    rdreg(1, 0, rd); check("R4 mode readback", rd, 8'h3C);
    check_pads("R6 mixed modes");

    // R7 sync latency and input enable
    @(negedge clk_i); pin_i = 8'h5A; in_en_i = 8'hFF;
    @(posedge clk_i); #1 req_i = 1; rmw_i = 0; reg_sel_i = 0;
    #1 check("R7 not after one edge", rdata_o, 8'h00); req_i = 0;
    @(posedge clk_i); #1 req_i = 1;
    #1 check("R7 after two edges", rdata_o, 8'h5A); req_i = 0;
    @(negedge clk_i); in_en_i = 8'h0F;
    rdreg(0, 0, rd); check("R7 input disabled", rd, 8'h0A);
    in_en_i = 8'hFF;

    // R8 rmw read ignores pins
    rdreg(0, 1, rd); check("R8 rmw latch", rd, exp_latch);

    // R9 alternate override in both modes
    @(negedge clk_i); alt_sel_i = 8'hF0; alt_out_i = 8'h96;
    check_pads("R9 alt override");
    wr(1, 2'd0, 0, 8'hAA);
    check_pads("R9 alt pp/od");
    rdreg(0, 1, rd); check("R9 latch unchanged", rd, exp_latch);
    @(negedge clk_i); alt_sel_i = 0;

    // R10 idle and read-only accesses hold state
    @(negedge clk_i); req_i = 0; we_i = 1; wdata_i = 8'h00; reg_sel_i = 0;
    @(posedge clk_i); #1 we_i = 0;
    @(negedge clk_i); req_i = 1; we_i = 0; wdata_i = 8'h11; reg_sel_i = 1;
    @(posedge clk_i); #1 req_i = 0;
    rdreg(0, 1, rd); check("R10 latch held", rd, exp_latch);
    rdreg(1, 0, rd); check("R10 mode held", rd, exp_mode);

    // random mix
    for (int n = 0; n < 300; n++) begin
      logic sel = 1'($urandom());
      wr(sel, 2'($urandom()), 3'($urandom()), 8'($urandom()));
      if (n % 3 == 0) begin
        @(negedge clk_i);
        pin_i = 8'($urandom()); in_en_i = 8'($urandom());
        alt_sel_i = 8'($urandom()); alt_out_i = 8'($urandom());
        repeat (2) @(posedge clk_i);
        rdreg(0, 0, rd); check("R7 random pins", rd, pin_i & in_en_i);
      end
      rdreg(0, 1, rd); check("R3 random latch", rd, exp_latch);
      rdreg(1, 0, rd); check("R4 random mode", rd, exp_mode);
      check_pads("R6 random pads");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule